// File: doc/BRIEF.md
# Two-Axis Memory Test Address Walker

This block produces the logical address sequence that a memory self-test engine walks through. The address space has two dimensions: a row axis (X) and a column/block axis (Y). Each axis has its own counter, and each counter's active width is set per test by a 4-bit width code. One axis is the fast axis and steps on every advanced cycle. The other is the slow axis and moves only when the fast axis wraps. The caller chooses which axis is fast and whether both count up or down. The walker reports each step it takes, and it reports when the whole two-dimensional space has been covered. It does not produce data patterns, compare results or map addresses to physical locations.

The engine sets the width codes, the direction and the fast-axis choice, then pulses `start_i`. The walker latches that setup, so later changes to the setup pins do not alter a sweep already in progress. The engine holds `advance_i` high on every cycle it is ready for the next address, and can stall the walker by dropping it for multi-cycle operations. A width code outside 2..10 raises `cfg_err_o`, and a start request made while it is high is refused.

The control is a three-state machine:
- `ST_IDLE`: waiting for a start.
- `ST_RUN`: walking.
- `ST_LAST`: one cycle that announces completion.

Transitions:
- `T_LOAD`: any state to `ST_RUN` on a valid start.
- `T_STEP`: `ST_RUN` to itself on an advanced, non-final step, or while stalled.
- `T_FINISH`: `ST_RUN` to `ST_LAST` on the advanced step taken while both counters are terminal.
- `T_RETIRE`: `ST_LAST` to `ST_IDLE`.

Top module: `bist_addr_walker`

## Requirements
- R1: A width code gives the number of active counter bits directly (code 2 = 2 bits ... code 10 = 10 bits). `cfg_err_o` is high in the same cycle, combinationally, whenever either code is 0, 1 or 11..15.
- R2: A start request made while `cfg_err_o` is high is ignored. The state, busy flag and counters are left as they were, and a sweep in progress continues.
- R3: A start made while `cfg_err_o` is low raises `busy_o` on the next cycle and loads both counters with their initial value. The initial value is 0 when counting up (`count_down_i`=0) and 2^w−1 when counting down (`count_down_i`=1).
- R4: While `advance_i` is low, and no start is made, both counter outputs hold and `step_o` stays low.
- R5: On each advanced cycle the fast counter moves by one in the latched direction. From its terminal value it wraps to its initial value. The terminal value is 2^w−1 when counting up and 0 when counting down.
- R6: The slow counter moves by one (or wraps) only on advanced steps in which the fast counter was at its terminal value.
- R7: `fast_is_y_i`=0 makes X the fast axis, and `fast_is_y_i`=1 makes Y the fast axis.
- R8: `step_o` is high for one cycle right after each advanced step taken in `ST_RUN`, including the final step.
- R9: The advanced step taken while both counters are terminal is the final step. The counters stay at their terminal values. On the next cycle `sweep_done_o` is high for exactly one cycle and `busy_o` is low. The counters then hold until a new valid start.
- R10: The bits of `x_addr_o` and `y_addr_o` above the latched width are always zero.
- R11: Width codes, direction and fast-axis select are latched at start. Changing them during a sweep has no effect on the sweep.
- R12: A valid start made in the same cycle as an advance takes priority. The counters reload, no step is counted, and the sweep restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse: latch setup, load initial values |
| advance_i | input | 1 | Step enable for the current cycle |
| fast_is_y_i | input | 1 | 1: Y is the fast axis, 0: X is the fast axis |
| count_down_i | input | 1 | 1: count down, 0: count up |
| x_width_code_i | input | CODE_W | X counter width code |
| y_width_code_i | input | CODE_W | Y counter width code |
| x_addr_o | output | MAX_W | X (row) counter value |
| y_addr_o | output | MAX_W | Y (column/block) counter value |
| step_o | output | 1 | A step was taken on the previous cycle |
| sweep_done_o | output | 1 | One-cycle pulse after the final step |
| busy_o | output | 1 | Sweep in progress |
| cfg_err_o | output | 1 | A width code is unsupported or reserved |

## Verification
Two functions can fall on the same clock edge: a new start, and a step or the sweep's final step. The bench drives `start_i` together with `advance_i` in the middle of a sweep. It also issues a start during the one-cycle completion state. It judges both cases by comparing the counters, `busy_o` and `step_o` on every clock against a behavioural model in which a start always wins over stepping. Refused starts with bad width codes are likewise applied during a running sweep. They are checked to leave the walk untouched.

// File: rtl/bist_addr_pkg.sv
package bist_addr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LAST = 2'd2
    } walk_state_t;

    localparam int AXES = 2;
    localparam int AX_X = 0;
    localparam int AX_Y = 1;

endpackage

// File: rtl/bist_width_decode.sv
module bist_width_decode #(
    parameter int CODE_W = 4,
    parameter int MIN_W  = 2,
    parameter int MAX_W  = 10
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              valid_o,
    output logic [MAX_W-1:0]  mask_o
);

    int code_val;

    always_comb begin
        code_val = int'(code_i);
        valid_o  = (code_val >= MIN_W) && (code_val <= MAX_W);
    end

    // one mask bit per counter position, set when below the coded width
    generate
        for (genvar b = 0; b < MAX_W; b++) begin : g_mask
            assign mask_o[b] = valid_o && (code_val > b);
        end
    endgenerate

endmodule

// File: rtl/bist_axis_counter.sv
module bist_axis_counter #(
    parameter int MAX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             load_down_i,
    input  logic [MAX_W-1:0] load_mask_i,
    input  logic             step_i,
    input  logic             down_i,
    input  logic [MAX_W-1:0] mask_i,
    output logic [MAX_W-1:0] cnt_o,
    output logic             term_o
);

    localparam logic [MAX_W-1:0] ONE = {{(MAX_W-1){1'b0}}, 1'b1};

    logic [MAX_W-1:0] cnt_q;
    logic [MAX_W-1:0] cnt_nxt;

    always_comb begin
        term_o = down_i ? (cnt_q == '0) : (cnt_q == mask_i);
        if (term_o) begin
            cnt_nxt = down_i ? mask_i : '0;
        end else if (down_i) begin
            cnt_nxt = (cnt_q - ONE) & mask_i;
        end else begin
            cnt_nxt = (cnt_q + ONE) & mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_down_i ? load_mask_i : '0;
        end else if (step_i) begin
            cnt_q <= cnt_nxt;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/bist_walk_fsm.sv
module bist_walk_fsm
    import bist_addr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cfg_ok_i,
    input  logic advance_i,
    input  logic fast_term_i,
    input  logic slow_term_i,
    output logic load_o,
    output logic fast_step_o,
    output logic slow_step_o,
    output logic busy_o,
    output logic step_done_o,
    output logic sweep_done_o
);

    walk_state_t state_q;
    walk_state_t state_d;
    logic        step_take;
    logic        step_q;

    // next-state process
    always_comb begin
        state_d = state_q;
        if (start_i && cfg_ok_i) begin
            state_d = ST_RUN;                                    // T_LOAD
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN: begin
                    if (advance_i && fast_term_i && slow_term_i) begin
                        state_d = ST_LAST;                       // T_FINISH
                    end else begin
                        state_d = ST_RUN;                        // T_STEP
                    end
                end
                ST_LAST: state_d = ST_IDLE;                      // T_RETIRE
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_take;
        end
    end

    // output process
    always_comb begin
        load_o       = start_i && cfg_ok_i;
        step_take    = 1'b0;
        fast_step_o  = 1'b0;
        slow_step_o  = 1'b0;
        busy_o       = 1'b0;
        sweep_done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                busy_o      = 1'b1;
                step_take   = advance_i && !load_o;
                fast_step_o = step_take && !(fast_term_i && slow_term_i);
                slow_step_o = fast_step_o && fast_term_i;
            end
            ST_LAST: sweep_done_o = 1'b1;
            default: ;
        endcase
    end

    assign step_done_o = step_q;

endmodule

// File: rtl/bist_addr_walker.sv
module bist_addr_walker
    import bist_addr_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int MIN_W  = 2,
    parameter int MAX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              advance_i,
    input  logic              fast_is_y_i,
    input  logic              count_down_i,
    input  logic [CODE_W-1:0] x_width_code_i,
    input  logic [CODE_W-1:0] y_width_code_i,
    output logic [MAX_W-1:0]  x_addr_o,
    output logic [MAX_W-1:0]  y_addr_o,
    output logic              step_o,
    output logic              sweep_done_o,
    output logic              busy_o,
    output logic              cfg_err_o
);

    logic [CODE_W-1:0] ax_code  [AXES];
    logic              ax_valid [AXES];
    logic [MAX_W-1:0]  ax_mask  [AXES];
    logic [MAX_W-1:0]  lat_mask [AXES];
    logic [MAX_W-1:0]  ax_cnt   [AXES];
    logic              ax_term  [AXES];
    logic              ax_step  [AXES];

    logic lat_down;
    logic lat_fast_y;
    logic cfg_ok;
    logic load;
    logic fast_step;
    logic slow_step;
    logic fast_term;
    logic slow_term;

    assign ax_code[AX_X] = x_width_code_i;
    assign ax_code[AX_Y] = y_width_code_i;

    assign cfg_ok    = ax_valid[AX_X] && ax_valid[AX_Y];
    assign cfg_err_o = !cfg_ok;

    assign fast_term = lat_fast_y ? ax_term[AX_Y] : ax_term[AX_X];
    assign slow_term = lat_fast_y ? ax_term[AX_X] : ax_term[AX_Y];

    assign ax_step[AX_X] = lat_fast_y ? slow_step : fast_step;
    assign ax_step[AX_Y] = lat_fast_y ? fast_step : slow_step;

    generate
        for (genvar a = 0; a < AXES; a++) begin : g_axis
            bist_width_decode #(
                .CODE_W (CODE_W),
                .MIN_W  (MIN_W),
                .MAX_W  (MAX_W)
            ) u_dec (
                .code_i  (ax_code[a]),
                .valid_o (ax_valid[a]),
                .mask_o  (ax_mask[a])
            );

            bist_axis_counter #(
                .MAX_W (MAX_W)
            ) u_cnt (
                .clk         (clk),
                .rst_n       (rst_n),
                .load_i      (load),
                .load_down_i (count_down_i),
                .load_mask_i (ax_mask[a]),
                .step_i      (ax_step[a]),
                .down_i      (lat_down),
                .mask_i      (lat_mask[a]),
                .cnt_o       (ax_cnt[a]),
                .term_o      (ax_term[a])
            );
        end
    endgenerate

    // setup captured at start so the sweep ignores later pin changes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < AXES; a++) begin
                lat_mask[a] <= '0;
            end
            lat_down   <= 1'b0;
            lat_fast_y <= 1'b0;
        end else if (load) begin
            for (int a = 0; a < AXES; a++) begin
                lat_mask[a] <= ax_mask[a];
            end
            lat_down   <= count_down_i;
            lat_fast_y <= fast_is_y_i;
        end
    end

    bist_walk_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cfg_ok_i     (cfg_ok),
        .advance_i    (advance_i),
        .fast_term_i  (fast_term),
        .slow_term_i  (slow_term),
        .load_o       (load),
        .fast_step_o  (fast_step),
        .slow_step_o  (slow_step),
        .busy_o       (busy_o),
        .step_done_o  (step_o),
        .sweep_done_o (sweep_done_o)
    );

    assign x_addr_o = ax_cnt[AX_X] & lat_mask[AX_X];
    assign y_addr_o = ax_cnt[AX_Y] & lat_mask[AX_Y];

endmodule

// File: rtl/bist_addr_walker_chk.sv
module bist_addr_walker_chk #(
    parameter int MAX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             advance_i,
    input logic             cfg_err_o,
    input logic             busy_o,
    input logic             step_o,
    input logic             sweep_done_o,
    input logic [MAX_W-1:0] x_addr_o,
    input logic [MAX_W-1:0] y_addr_o
);

    assert_valid_start_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !cfg_err_o) |=> busy_o);

    assert_bad_start_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && cfg_err_o && !busy_o) |=> !busy_o);

    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !advance_i && !start_i) |=> ($stable(x_addr_o) && $stable(y_addr_o) && !step_o));

    assert_step_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> $past(busy_o));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done_o |=> !sweep_done_o);

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done_o |-> !busy_o);

endmodule

bind bist_addr_walker bist_addr_walker_chk #(.MAX_W(MAX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .advance_i    (advance_i),
    .cfg_err_o    (cfg_err_o),
    .busy_o       (busy_o),
    .step_o       (step_o),
    .sweep_done_o (sweep_done_o),
    .x_addr_o     (x_addr_o),
    .y_addr_o     (y_addr_o)
);

// File: tb/bist_addr_walker_tb_top.sv
`timescale 1ns/1ps
module bist_addr_walker_tb_top;

    localparam int CODE_W = 4;
    localparam int MAX_W  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              adv = 1'b0;
    logic              fy = 1'b0;
    logic              dn = 1'b0;
    logic [CODE_W-1:0] xc = 4'd2;
    logic [CODE_W-1:0] yc = 4'd2;
    logic [MAX_W-1:0]  x_addr;
    logic [MAX_W-1:0]  y_addr;
    logic              step, done, busy, cfg_err;

    always #10 clk = ~clk;

    bist_addr_walker #(.CODE_W(CODE_W), .MIN_W(2), .MAX_W(MAX_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .advance_i      (adv),
        .fast_is_y_i    (fy),
        .count_down_i   (dn),
        .x_width_code_i (xc),
        .y_width_code_i (yc),
        .x_addr_o       (x_addr),
        .y_addr_o       (y_addr),
        .step_o         (step),
        .sweep_done_o   (done),
        .busy_o         (busy),
        .cfg_err_o      (cfg_err)
    );

    int    n_run = 0;
    int    n_fail = 0;
    int    mx = 0, my = 0, mxw = 0, myw = 0;
    bit    mdown = 0, mfy = 0, mbusy = 0, mdone = 0, mstep = 0;
    string cur_tag = "RST";

    function automatic bit bad_code(int c);
        return (c < 2) || (c > 10);
    endfunction

    function automatic bit at_end(int v, int w, bit d);
        return d ? (v == 0) : (v == (1 << w) - 1);
    endfunction

    function automatic int bump(int v, int w, bit d);
        int top = (1 << w) - 1;
        if (d) return (v == 0) ? top : v - 1;
        return (v == top) ? 0 : v + 1;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: advance state by one clock edge using current inputs
    task automatic model_edge();
        bit err = bad_code(int'(xc)) || bad_code(int'(yc));
        bit nstep = 0, ndone = 0;
        if (start && !err) begin
            mxw = int'(xc); myw = int'(yc); mdown = dn; mfy = fy;
            mx = mdown ? (1 << mxw) - 1 : 0;
            my = mdown ? (1 << myw) - 1 : 0;
            mbusy = 1;
        end else if (mbusy && adv) begin
            bit xt = at_end(mx, mxw, mdown);
            bit yt = at_end(my, myw, mdown);
            nstep = 1;
            if (xt && yt) begin
                mbusy = 0;
                ndone = 1;
            end else if (!mfy) begin
                mx = bump(mx, mxw, mdown);
                if (xt) my = bump(my, myw, mdown);
            end else begin
                my = bump(my, myw, mdown);
                if (yt) mx = bump(mx, mxw, mdown);
            end
        end
        mstep = nstep;
        mdone = ndone;
    endtask

    task automatic compare();
        string xtag = mfy ? "R6 R7" : "R5";
        string ytag = mfy ? "R5 R7" : "R6";
        chk({xtag, " x ", cur_tag}, int'(x_addr), mx);
        chk({ytag, " y ", cur_tag}, int'(y_addr), my);
        chk({"R8 step ", cur_tag}, int'(step), int'(mstep));
        chk({"R9 done ", cur_tag}, int'(done), int'(mdone));
        chk({"R3 busy ", cur_tag}, int'(busy), int'(mbusy));
        chk("R10 x upper", int'(x_addr) >> mxw, 0);
        chk("R10 y upper", int'(y_addr) >> myw, 0);
    endtask

    task automatic cyc(bit s, bit a);
        start = s;
        adv = a;
        #1;
        chk({"R1 cfg_err ", cur_tag}, int'(cfg_err),
            int'(bad_code(int'(xc)) || bad_code(int'(yc))));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic run_to_done(int limit);
        for (int i = 0; i < limit; i++) begin
            cyc(0, 1);
            if (mdone) break;
        end
    endtask

    task automatic go(int xw, int yw, bit d, bit f);
        xc = CODE_W'(xw); yc = CODE_W'(yw); dn = d; fy = f;
        cyc(1, 0);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        // R1: every code, against a valid partner
        cur_tag = "R1";
        for (int c = 0; c < 16; c++) begin
            xc = CODE_W'(c); yc = 4'd5;
            cyc(0, 0);
            xc = 4'd5; yc = CODE_W'(c);
            cyc(0, 0);
        end

        // R2: refused start while idle
        cur_tag = "R2 idle";
        xc = 4'd1; yc = 4'd3;
        cyc(1, 1);
        xc = 4'd3; yc = 4'd11;
        cyc(1, 0);

        // R3 R5 R6 R8 R9: 2x2 up, X fast
        cur_tag = "R3 up";
        go(2, 2, 0, 0);
        cur_tag = "R9 sweep";
        run_to_done(100);
        chk("R9 done reached", int'(mdone), 1);
        cur_tag = "R9 hold";
        for (int i = 0; i < 3; i++) cyc(0, 1);

        // R7 with down count, Y fast
        cur_tag = "R7 down";
        go(3, 2, 1, 1);
        run_to_done(200);

        // R4: stalls interleaved
        cur_tag = "R4 stall";
        go(2, 3, 0, 1);
        for (int i = 0; i < 40; i++) cyc(0, (i % 3) == 0);
        run_to_done(200);

        // R11: pin changes mid-sweep ignored
        cur_tag = "R11";
        go(2, 3, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 1);
        xc = 4'd9; yc = 4'd4; dn = 1; fy = 1;
        run_to_done(200);

        // R2 during run, R12 start with advance
        cur_tag = "R2 run";
        go(3, 3, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 1);
        yc = 4'd12;
        cyc(1, 1);
        cyc(0, 1);
        cur_tag = "R12";
        yc = 4'd2; xc = 4'd2; dn = 1;
        cyc(1, 1);
        run_to_done(100);
        // start landing on the completion cycle
        cur_tag = "R12 last";
        xc = 4'd2; yc = 4'd2; dn = 0;
        cyc(1, 1);

        // R10: widest row axis
        cur_tag = "R10 wide";
        go(10, 2, 0, 0);
        run_to_done(5000);
        go(2, 10, 1, 0);
        run_to_done(5000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule